// File: doc/BRIEF.md
# Carrier Gap Command Transmitter

This block sends reader-to-transponder commands over a low-frequency link by switching the carrier field on and off. Time is counted in carrier cycles. A parameter sets how many system clocks make up one carrier cycle. Each transmitted bit fills 64 carrier cycles. A zero is sent as a timed pattern of field gaps within those 64 cycles. A one leaves the field on for the whole bit period.

A start strobe captures a command byte and a 32-bit argument word. The block then serialises a 54-bit frame:

- the command byte, followed by its parity bit;
- the four argument bytes, each followed by its parity bit;
- a column-parity byte, with no parity bit;
- a stop bit of zero.

A separate request strobe sends only two zero bits. A controller uses this to ask the transponder to accept a command. The busy output tells the controller when the line is free again. Typical command codes are 0x01, 0x12 and 0x0A.

Top module: `fm_field_tx`

## Requirements
- R1: After reset, busy_o is 0 and field_en_o is 1 (field on).
- R2: Every bit lasts exactly 64 carrier cycles. One carrier cycle is CARRIER_DIV clocks. Carrier cycles are counted from the first clock after the strobe is sampled.
- R3: A zero bit drives field_en_o to 0 in carrier cycles 0..6 of its period, to 1 in cycles 7..31, and to 0 in cycles 32..63.
- R4: A one bit holds field_en_o at 1 for all 64 carrier cycles.
- R5: A frame begins with cmd_code_i, sent MSB first, followed by a parity bit equal to the XOR of its 8 bits. Next come the argument bytes cmd_word_i[31:24], [23:16], [15:8] and [7:0], in that order. Each byte is sent MSB first and followed by its own XOR parity bit.
- R6: After the four argument bytes, the frame sends the XOR of those bytes MSB first with no parity bit. A stop bit of 0 closes the frame, for 54 bits in total.
- R7: A request strobe (rm_req_i) while idle sends exactly two zero bits.
- R8: busy_o is 1 from the clock after an accepted strobe until the last bit period ends. After that, field_en_o returns to 1.
- R9: Strobes that arrive while busy_o is 1 are ignored. The frame in progress keeps its waveform and length.
- R10: If start_i and rm_req_i are both high in the same idle cycle, the frame is sent and the request is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe; captures the command byte and the argument word |
| cmd_code_i | input | 8 | Command byte |
| cmd_word_i | input | 32 | Argument word |
| rm_req_i | input | 1 | Request strobe; sends two zero bits |
| busy_o | output | 1 | Transmission in progress |
| field_en_o | output | 1 | Carrier field enable (1 = field on) |

## Verification
Two pairs of functions can meet in one cycle. The first pair is the frame start and the request strobe: the bench raises both in the same idle cycle. It then judges the result by the busy length, which must equal a full 54-bit frame and not two bits, and by the waveform of every clock, which must follow the frame. The second pair is a running transmission and a new strobe: the bench pulses both strobes with different data in the middle of a frame. The per-clock waveform and the busy length must stay those of the original frame.

// File: rtl/fm_pkg.sv
package fm_pkg;
    localparam int BIT_CARRIERS = 64;
    localparam int GAP_HEAD     = 7;
    localparam int HALF_POINT   = 32;
    localparam int BYTE_BITS    = 8;
    localparam int WORD_BYTES   = 4;
    localparam int FRAME_BITS   = (BYTE_BITS + 1) * (WORD_BYTES + 1) + BYTE_BITS + 1;
    localparam int RM_BITS      = 2;
    localparam int PHASE_W      = $clog2(BIT_CARRIERS);
    localparam int LEFT_W       = $clog2(FRAME_BITS + 1);

    typedef struct packed {
        logic                  busy;
        logic [FRAME_BITS-1:0] sreg;
        logic [LEFT_W-1:0]     left;
        logic [PHASE_W-1:0]    phase;
    } tx_state_t;
endpackage

// File: rtl/fm_carrier_div.sv
module fm_carrier_div #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick = run && (cnt_q == CW'(DIV - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (!run)      cnt_d = '0;
        else if (tick) cnt_d = '0;
        else           cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_TICK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !tick); // R2
endmodule

// File: rtl/fm_frame_pack.sv
module fm_frame_pack
    import fm_pkg::*;
(
    input  logic [BYTE_BITS-1:0]            code,
    input  logic [WORD_BYTES*BYTE_BITS-1:0] word,
    output logic [FRAME_BITS-1:0]           frame
);
    logic [BYTE_BITS-1:0] col;

    always_comb begin
        col = '0;
        for (int b = 0; b < WORD_BYTES; b++)
            col ^= word[(WORD_BYTES-1-b)*BYTE_BITS +: BYTE_BITS];
    end

    assign frame[FRAME_BITS-1 -: BYTE_BITS+1] = {code, ^code};

    for (genvar g = 0; g < WORD_BYTES; g++) begin : g_row
        localparam int TOP = FRAME_BITS - 1 - (g + 1) * (BYTE_BITS + 1);
        wire [BYTE_BITS-1:0] by = word[(WORD_BYTES-1-g)*BYTE_BITS +: BYTE_BITS];
        assign frame[TOP -: BYTE_BITS+1] = {by, ^by};
    end

    assign frame[BYTE_BITS:1] = col;
    assign frame[0]           = 1'b0;
endmodule

// File: rtl/fm_bit_shaper.sv
module fm_bit_shaper
    import fm_pkg::*;
(
    input  logic               bit_val,
    input  logic [PHASE_W-1:0] phase,
    output logic               level
);
    always_comb begin
        if (bit_val) level = 1'b1;
        else         level = (phase >= PHASE_W'(GAP_HEAD)) && (phase < PHASE_W'(HALF_POINT));
    end
endmodule

// File: rtl/fm_field_tx.sv
module fm_field_tx
    import fm_pkg::*;
#(
    parameter int CARRIER_DIV = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [7:0]  cmd_code_i,
    input  logic [31:0] cmd_word_i,
    input  logic        rm_req_i,
    output logic        busy_o,
    output logic        field_en_o
);
    localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(BIT_CARRIERS - 1);

    tx_state_t s_d, s_q;
    logic tick, level, cur_bit;
    logic [FRAME_BITS-1:0] frame;

    fm_carrier_div #(.DIV(CARRIER_DIV)) u_div (
        .clk(clk), .rst_n(rst_n), .run(s_q.busy), .tick(tick));

    fm_frame_pack u_pack (.code(cmd_code_i), .word(cmd_word_i), .frame(frame));

    assign cur_bit = s_q.sreg[FRAME_BITS-1];

    fm_bit_shaper u_shape (.bit_val(cur_bit), .phase(s_q.phase), .level(level));

    always_comb begin
        s_d = s_q;
        if (!s_q.busy && start_i) begin
            s_d.busy  = 1'b1;
            s_d.sreg  = frame;
            s_d.left  = LEFT_W'(FRAME_BITS);
            s_d.phase = '0;
        end else if (!s_q.busy && rm_req_i) begin
            s_d.busy  = 1'b1;
            s_d.sreg  = '0;
            s_d.left  = LEFT_W'(RM_BITS);
            s_d.phase = '0;
        end else if (s_q.busy && tick) begin
            if (s_q.phase == LAST_PHASE) begin
                s_d.phase = '0;
                if (s_q.left == LEFT_W'(1)) begin
                    s_d.busy = 1'b0;
                    s_d.left = '0;
                end else begin
                    s_d.sreg = {s_q.sreg[FRAME_BITS-2:0], 1'b0};
                    s_d.left = s_q.left - 1'b1;
                end
            end else begin
                s_d.phase = s_q.phase + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy_o     = s_q.busy;
    assign field_en_o = !s_q.busy || level;

    AST_IDLE_FIELD_ON: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> field_en_o); // R8
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && (start_i || rm_req_i)) |=> busy_o); // R8
    AST_END_ON_LAST_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(s_q.phase) == LAST_PHASE); // R2
    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !tick) |=> $stable(s_q.phase)); // R2
    AST_ZERO_HEAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !cur_bit && s_q.phase < PHASE_W'(GAP_HEAD)) |-> !field_en_o); // R3
    AST_ONE_FIELD_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && cur_bit) |-> field_en_o); // R4
endmodule

// File: tb/sim_fm_field_tx.sv
`timescale 1ns/1ps
module sim_fm_field_tx;
    localparam int DIV       = 2;
    localparam int BITCLK    = 64 * DIV;
    localparam int NFRAME    = 54;
    localparam int WD_LIMIT  = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic rm_req_i = 1'b0;
    logic [7:0] cmd_code_i = '0;
    logic [31:0] cmd_word_i = '0;
    logic busy_o, field_en_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fm_field_tx #(.CARRIER_DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_code_i(cmd_code_i),
        .cmd_word_i(cmd_word_i), .rm_req_i(rm_req_i),
        .busy_o(busy_o), .field_en_o(field_en_o));

    function automatic logic frame_bit(input logic [7:0] c, input logic [31:0] w, input int idx);
        logic [7:0] by;
        logic [7:0] col;
        if (idx < 8)  return c[7-idx];
        if (idx == 8) return ^c;
        if (idx < 45) begin
            by = w[31 - 8*((idx-9)/9) -: 8];
            if ((idx-9) % 9 == 8) return ^by;
            return by[7 - (idx-9)%9];
        end
        col = w[31:24] ^ w[23:16] ^ w[15:8] ^ w[7:0];
        if (idx < 53) return col[7-(idx-45)];
        return 1'b0;
    endfunction

    function automatic logic exp_level(input logic b, input int k);
        int ph;
        ph = (k % BITCLK) / DIV;
        if (b) return 1'b1;
        return (ph >= 7) && (ph < 32);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_tx(input bit rm, input bit both, input logic [7:0] c, input logic [31:0] w,
                          input int inject_at, input string tag);
        int nbits, errs, first_bad_k, first_act, blen;
        logic b;
        nbits = rm ? 2 : NFRAME;
        errs = 0; first_bad_k = -1; first_act = 0; blen = 0;
        @(negedge clk);
        cmd_code_i = c; cmd_word_i = w;
        start_i = !rm || both;
        rm_req_i = rm || both;
        @(negedge clk);
        start_i = 1'b0; rm_req_i = 1'b0;
        for (int k = 0; k < nbits * BITCLK; k++) begin
            b = rm ? 1'b0 : frame_bit(c, w, k / BITCLK);
            if (busy_o) blen++;
            if (field_en_o !== exp_level(b, k)) begin
                errs++;
                if (first_bad_k < 0) begin first_bad_k = k; first_act = field_en_o; end
            end
            if (k == inject_at) begin
                cmd_code_i = ~c; cmd_word_i = ~w;
                start_i = 1'b1; rm_req_i = 1'b1;
            end else if (k == inject_at + 1) begin
                start_i = 1'b0; rm_req_i = 1'b0;
            end
            @(negedge clk);
        end
        check(errs == 0, {tag, " waveform (R2 R3 R4 R5 R6)"}, first_act, first_bad_k);
        check(blen == nbits * BITCLK, {tag, " busy length R8"}, blen, nbits * BITCLK);
        check(!busy_o && field_en_o, {tag, " idle after end R8"}, {busy_o, field_en_o}, 1);
    endtask

    task automatic shape_probe(input logic [7:0] c, input string tag, input bit expect_one);
        int lv[3];
        int ph[3] = '{3, 10, 40};
        @(negedge clk);
        cmd_code_i = c; cmd_word_i = '0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < NFRAME * BITCLK; k++) begin
            for (int j = 0; j < 3; j++) if (k == ph[j] * DIV) lv[j] = field_en_o;
            @(negedge clk);
        end
        if (expect_one) begin
            check(lv[0] == 1 && lv[1] == 1 && lv[2] == 1, {tag, " R4 one bit stays on"}, lv[0]+lv[1]+lv[2], 3);
        end else begin
            check(lv[0] == 0, {tag, " R3 head gap"}, lv[0], 0);
            check(lv[1] == 1, {tag, " R3 middle on"}, lv[1], 1);
            check(lv[2] == 0, {tag, " R3 tail gap"}, lv[2], 0);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == WD_LIMIT && !done) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WD_LIMIT);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] codes[3] = '{8'h01, 8'h12, 8'h0A};
        void'($urandom(32'd1234));
        #1;
        check(busy_o == 0 && field_en_o == 1, "R1 during reset", {busy_o, field_en_o}, 1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy_o == 0 && field_en_o == 1, "R1 after reset", {busy_o, field_en_o}, 1);

        shape_probe(8'h00, "zero bit", 1'b0);
        shape_probe(8'hFF, "one bit", 1'b1);
        run_tx(1'b1, 1'b0, 8'h00, 32'h0, -5, "R7 request");
        run_tx(1'b0, 1'b0, 8'h01, 32'h0000_0000, -5, "R5 login zero word");
        run_tx(1'b0, 1'b0, 8'h12, 32'hFFFF_FFFF, -5, "R6 write ones");
        run_tx(1'b0, 1'b1, 8'h0A, 32'h0021_0000, -5, "R10 both strobes");
        run_tx(1'b0, 1'b0, 8'h12, 32'hA5C3_0F81, 1000, "R9 strobe mid frame");
        run_tx(1'b1, 1'b0, 8'h00, 32'h0, 40, "R9 strobe mid request");
        for (int i = 0; i < 4; i++)
            run_tx(1'b0, 1'b0, codes[$urandom % 3], $urandom, -5, "R5 random frame");
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule